// File: doc/BRIEF.md
# Multistage Shuffle-Exchange Packet Router

This block connects eight sources to eight sinks through three columns of two-by-two switches. A perfect-shuffle permutation sits in front of every column: the line list is cut into an upper and a lower half, and the two halves are interleaved. Every source offers a valid bit, a three-bit port tag and a data word in each cycle. The switches steer the packet using one tag bit per column, most significant bit first. As a result the packet leaves on the output port whose number equals its tag. Every path crosses exactly three switches.

The routing fabric contains no storage. At a switch where two packets need the same exit, the packet on the upper switch input goes on and the other is dropped. A busy flag is then raised back to the source of the dropped packet. Delivered packets and busy flags are captured in one rank of registers. The results therefore appear one clock after the inputs are sampled. A source that sees busy must present its packet again later if it still wants to send it.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted, and until the first packets are sampled after reset, every out_valid bit and every in_busy bit is 0.
- R2: A lone valid packet from any source with any tag is delivered on output port tag, with its data unchanged, and its source sees no busy.
- R3: The outputs are registered. Results for inputs sampled at one rising edge appear after that edge and hold until the next edge.
- R4: Before each column, line i moves to line ((2*i) mod 8) + (i / 4), which is a left rotation of the three-bit index. Switch s takes line 2s as its upper input and line 2s+1 as its lower input. Column k (k = 0, 1, 2) steers on tag bit 2-k: a 0 selects the upper exit and a 1 selects the lower exit.
- R5: When both packets at a switch need the same exit, the packet on the upper input wins. For example, at the first column, inputs i and i+4 (i < 4) meet, and input i wins when both tags have the same bit 2.
- R6: A packet that loses at any switch appears on no output, and its source has in_busy set in the same cycle as the other results.
- R7: An input with in_valid = 0 is never flagged busy, is never delivered, and never causes a busy flag on another input, whatever its tag and data.
- R8: Every valid input is either delivered on exactly one output or flagged busy, never both. The number of set out_valid bits plus the number of set in_busy bits therefore equals the number of valid inputs.
- R9: Any cyclic shift pattern in which all inputs are valid and input i has tag (i + c) mod 8 is delivered in full, with no busy flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 8 | Valid bit per source |
| in_dst | input | 24 | Three-bit output-port tag per source; source i uses bits [3i+2:3i] |
| in_data | input | 64 | Eight-bit data word per source; source i uses bits [8i+7:8i] |
| out_valid | output | 8 | Packet present on each output port |
| out_data | output | 64 | Data word per output port; port j uses bits [8j+7:8j], meaningful only while out_valid[j] is 1 |
| in_busy | output | 8 | Per source: the packet was blocked at a switch |

## Verification
The hardest situations to produce from the ports are collisions in the second or third column. Two packets that took different first-column switches meet again deeper in the network, so the winner is decided by where the shuffle has placed them rather than by their input numbers. The bench reaches these cases with an exhaustive sweep over every pair of sources and every pair of tags, followed by many pseudo-random masks and tag sets. The expected outcome is computed arithmetically: after column k, a packet's line is a three-bit window of the six-bit value formed by source and tag concatenated. Cyclic shifts and lone packets cover the patterns that are fully routable.

// File: rtl/omega_net_pkg.sv
package omega_net_pkg;

  localparam int unsigned DEF_PORTS  = 8;
  localparam int unsigned DEF_WORD_W = 8;

  // Perfect-shuffle target of line idx in a network of 2**lg lines:
  // left rotation of the line index by one bit.
  function automatic int unsigned shuffle_to(input int unsigned idx, input int unsigned lg);
    int unsigned msk;
    msk = (1 << lg) - 1;
    return ((idx << 1) | (idx >> (lg - 1))) & msk;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int unsigned LG  = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned SEL = 2
) (
  input  logic          up_v,
  input  logic [LG-1:0] up_src,
  input  logic [LG-1:0] up_dst,
  input  logic [DW-1:0] up_dat,
  input  logic          lo_v,
  input  logic [LG-1:0] lo_src,
  input  logic [LG-1:0] lo_dst,
  input  logic [DW-1:0] lo_dat,
  output logic          n_v,
  output logic [LG-1:0] n_src,
  output logic [LG-1:0] n_dst,
  output logic [DW-1:0] n_dat,
  output logic          s_v,
  output logic [LG-1:0] s_src,
  output logic [LG-1:0] s_dst,
  output logic [DW-1:0] s_dat,
  output logic          lose_v,
  output logic [LG-1:0] lose_src
);

  logic up_bit;
  logic lo_bit;
  logic clash;

  always_comb begin
    up_bit = up_dst[SEL];
    lo_bit = lo_dst[SEL];
    clash  = up_v && lo_v && (up_bit == lo_bit);

    n_v   = 1'b0;
    n_src = '0;
    n_dst = '0;
    n_dat = '0;
    if (up_v && !up_bit) begin
      n_v   = 1'b1;
      n_src = up_src;
      n_dst = up_dst;
      n_dat = up_dat;
    end else if (lo_v && !lo_bit) begin
      n_v   = 1'b1;
      n_src = lo_src;
      n_dst = lo_dst;
      n_dat = lo_dat;
    end

    s_v   = 1'b0;
    s_src = '0;
    s_dst = '0;
    s_dat = '0;
    if (up_v && up_bit) begin
      s_v   = 1'b1;
      s_src = up_src;
      s_dst = up_dst;
      s_dat = up_dat;
    end else if (lo_v && lo_bit) begin
      s_v   = 1'b1;
      s_src = lo_src;
      s_dst = lo_dst;
      s_dat = lo_dat;
    end

    // upper input has priority, so the lower one is the loser
    lose_v   = clash;
    lose_src = lo_src;
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int unsigned P   = 8,
  parameter int unsigned LG  = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned STG = 0
) (
  input  logic [P-1:0]         i_v,
  input  logic [P-1:0][LG-1:0] i_src,
  input  logic [P-1:0][LG-1:0] i_dst,
  input  logic [P-1:0][DW-1:0] i_dat,
  output logic [P-1:0]         o_v,
  output logic [P-1:0][LG-1:0] o_src,
  output logic [P-1:0][LG-1:0] o_dst,
  output logic [P-1:0][DW-1:0] o_dat,
  output logic [P-1:0]         o_busy
);

  localparam int unsigned HALF = P / 2;
  localparam int unsigned SEL  = LG - 1 - STG;

  logic [P-1:0]         sh_v;
  logic [P-1:0][LG-1:0] sh_src;
  logic [P-1:0][LG-1:0] sh_dst;
  logic [P-1:0][DW-1:0] sh_dat;
  logic [HALF-1:0]          lose_v;
  logic [HALF-1:0][LG-1:0]  lose_src;

  for (genvar i = 0; i < P; i++) begin : g_shuf
    localparam int unsigned TGT = omega_net_pkg::shuffle_to(i, LG);
    assign sh_v[TGT]   = i_v[i];
    assign sh_src[TGT] = i_src[i];
    assign sh_dst[TGT] = i_dst[i];
    assign sh_dat[TGT] = i_dat[i];
  end

  for (genvar s = 0; s < HALF; s++) begin : g_sw
    omega_switch #(.LG(LG), .DW(DW), .SEL(SEL)) u_sw (
      .up_v    (sh_v[2*s]),
      .up_src  (sh_src[2*s]),
      .up_dst  (sh_dst[2*s]),
      .up_dat  (sh_dat[2*s]),
      .lo_v    (sh_v[2*s+1]),
      .lo_src  (sh_src[2*s+1]),
      .lo_dst  (sh_dst[2*s+1]),
      .lo_dat  (sh_dat[2*s+1]),
      .n_v     (o_v[2*s]),
      .n_src   (o_src[2*s]),
      .n_dst   (o_dst[2*s]),
      .n_dat   (o_dat[2*s]),
      .s_v     (o_v[2*s+1]),
      .s_src   (o_src[2*s+1]),
      .s_dst   (o_dst[2*s+1]),
      .s_dat   (o_dat[2*s+1]),
      .lose_v  (lose_v[s]),
      .lose_src(lose_src[s])
    );
  end

  // map each loser back to a one-hot flag on its source
  always_comb begin
    o_busy = '0;
    for (int s = 0; s < HALF; s++) begin
      if (lose_v[s]) o_busy[lose_src[s]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int unsigned P  = omega_net_pkg::DEF_PORTS,
  parameter int unsigned DW = omega_net_pkg::DEF_WORD_W,
  parameter int unsigned LG = $clog2(P)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P-1:0]    in_valid,
  input  logic [P*LG-1:0] in_dst,
  input  logic [P*DW-1:0] in_data,
  output logic [P-1:0]    out_valid,
  output logic [P*DW-1:0] out_data,
  output logic [P-1:0]    in_busy
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  // line bundles between columns
  logic [P-1:0]         ln_v   [LG+1];
  logic [P-1:0][DW-1:0] ln_dat [LG+1];
  logic [P-1:0][LG-1:0] ln_src [LG];
  logic [P-1:0][LG-1:0] ln_dst [LG];
  logic [P-1:0]         stg_busy [LG];
  logic [P-1:0][LG-1:0] tail_src_unused;
  logic [P-1:0][LG-1:0] tail_dst_unused;

  for (genvar i = 0; i < P; i++) begin : g_src
    assign ln_v[0][i]   = in_valid[i];
    assign ln_src[0][i] = LG'(i);
    assign ln_dst[0][i] = in_dst[i*LG +: LG];
    assign ln_dat[0][i] = in_data[i*DW +: DW];
  end

  for (genvar k = 0; k < LG; k++) begin : g_col
    if (k == LG - 1) begin : g_last
      omega_stage #(.P(P), .LG(LG), .DW(DW), .STG(k)) u_stage (
        .i_v   (ln_v[k]),
        .i_src (ln_src[k]),
        .i_dst (ln_dst[k]),
        .i_dat (ln_dat[k]),
        .o_v   (ln_v[k+1]),
        .o_src (tail_src_unused),
        .o_dst (tail_dst_unused),
        .o_dat (ln_dat[k+1]),
        .o_busy(stg_busy[k])
      );
    end else begin : g_mid
      omega_stage #(.P(P), .LG(LG), .DW(DW), .STG(k)) u_stage (
        .i_v   (ln_v[k]),
        .i_src (ln_src[k]),
        .i_dst (ln_dst[k]),
        .i_dat (ln_dat[k]),
        .o_v   (ln_v[k+1]),
        .o_src (ln_src[k+1]),
        .o_dst (ln_dst[k+1]),
        .o_dat (ln_dat[k+1]),
        .o_busy(stg_busy[k])
      );
    end
  end

  // next-state
  logic [P-1:0]    valid_d;
  logic [P-1:0]    busy_d;
  logic [P*DW-1:0] data_d;
  logic [P-1:0]    data_en;

  always_comb begin
    valid_d = ln_v[LG];
    busy_d  = '0;
    for (int k = 0; k < LG; k++) busy_d = busy_d | stg_busy[k];
    for (int j = 0; j < P; j++) data_d[j*DW +: DW] = ln_dat[LG][j];
    data_en = ln_v[LG];
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      out_valid <= '0;
      in_busy   <= '0;
    end else begin
      out_valid <= valid_d;
      in_busy   <= busy_d;
    end
  end

  // data lanes load only when a packet arrives on them
  for (genvar j = 0; j < P; j++) begin : g_dreg
    always_ff @(posedge clk or negedge rst_sync) begin
      if (!rst_sync)       out_data[j*DW +: DW] <= '0;
      else if (data_en[j]) out_data[j*DW +: DW] <= data_d[j*DW +: DW];
    end
  end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int unsigned P  = 8,
  parameter int unsigned LG = 3
) (
  input logic            clk,
  input logic            rst_q,
  input logic [P-1:0]    in_valid,
  input logic [P*LG-1:0] in_dst,
  input logic [P-1:0]    out_valid,
  input logic [P-1:0]    in_busy
);

  logic         armed;
  logic [P-1:0] dest_hit;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    dest_hit = '0;
    for (int i = 0; i < P; i++) begin
      if (in_valid[i]) dest_hit[in_dst[i*LG +: LG]] = 1'b1;
    end
  end

  // R2
  route_dest_chk: assert property (@(posedge clk) disable iff (!armed)
    (out_valid & ~$past(dest_hit)) == '0);

  // R7
  busy_src_chk: assert property (@(posedge clk) disable iff (!armed)
    (in_busy & ~$past(in_valid)) == '0);

  // R8
  conserve_chk: assert property (@(posedge clk) disable iff (!armed)
    ($countones(out_valid) + $countones(in_busy)) == $past($countones(in_valid)));

  // R2
  lone_clear_chk: assert property (@(posedge clk) disable iff (!armed)
    $past($countones(in_valid) == 1) |-> (in_busy == '0 && $countones(out_valid) == 1));

endmodule

bind omega_net omega_net_chk #(.P(P), .LG(LG)) u_chk (
  .clk      (clk),
  .rst_q    (rst_sync),
  .in_valid (in_valid),
  .in_dst   (in_dst),
  .out_valid(out_valid),
  .in_busy  (in_busy)
);

// File: tb/omega_net_test.sv
module omega_net_test;

  localparam int P  = 8;
  localparam int LG = 3;
  localparam int DW = 8;

  logic            clk;
  logic            rst_n;
  logic [P-1:0]    in_valid;
  logic [P*LG-1:0] in_dst;
  logic [P*DW-1:0] in_data;
  logic [P-1:0]    out_valid;
  logic [P*DW-1:0] out_data;
  logic [P-1:0]    in_busy;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] lfsr = 16'hACE1;

  omega_net #(.P(P), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .in_busy(in_busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int win(int s, int d, int k);
    return (((s << LG) | d) >> (LG - k)) & (P - 1);
  endfunction

  task automatic step_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic check(input string tag, input logic ok, input logic [P-1:0] av,
                       input logic [P-1:0] ab, input logic [P-1:0] xv, input logic [P-1:0] xb);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: valid=%b busy=%b expected valid=%b busy=%b", tag, av, ab, xv, xb);
    end
  endtask

  task automatic run_vec(input logic [P-1:0] v, input logic [P*LG-1:0] ds,
                         input logic [P*DW-1:0] dt, input string tag);
    logic [P-1:0]    alive = v;
    logic [P-1:0]    eb = '0;
    logic [P-1:0]    ev = '0;
    logic [P*DW-1:0] ed = '0;
    logic [P*DW-1:0] msk = '0;
    for (int k = 1; k <= LG; k++) begin
      for (int a = 0; a < P; a++) begin
        for (int b = a + 1; b < P; b++) begin
          int da = int'(ds[a*LG +: LG]);
          int db = int'(ds[b*LG +: LG]);
          if (alive[a] && alive[b] && win(a, da, k) == win(b, db, k)) begin
            if (((win(a, da, k - 1) >> (LG - 1)) & 1) == 1) begin
              alive[a] = 1'b0; eb[a] = 1'b1;
            end else begin
              alive[b] = 1'b0; eb[b] = 1'b1;
            end
          end
        end
      end
    end
    for (int a = 0; a < P; a++) begin
      if (alive[a]) begin
        int d = int'(ds[a*LG +: LG]);
        ev[d] = 1'b1;
        ed[d*DW +: DW] = dt[a*DW +: DW];
        msk[d*DW +: DW] = '1;
      end
    end
    @(negedge clk);
    in_valid = v; in_dst = ds; in_data = dt;
    @(posedge clk);
    @(negedge clk);
    check(tag, (out_valid == ev) && (in_busy == eb) && ((out_data & msk) == ed),
          out_valid, in_busy, ev, eb);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = '0; in_dst = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 in reset", (out_valid == '0) && (in_busy == '0), out_valid, in_busy, '0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", (out_valid == '0) && (in_busy == '0), out_valid, in_busy, '0, '0);

    // R3: registered, one-cycle latency
    @(negedge clk);
    in_valid = 8'h04; in_dst = '0; in_dst[2*LG +: LG] = 3'd5; in_data[2*DW +: DW] = 8'h3C;
    #1;
    check("R3 before edge", out_valid == '0, out_valid, in_busy, '0, '0);
    @(posedge clk); #1;
    check("R3 after edge", (out_valid == 8'h20) && (out_data[5*DW +: DW] == 8'h3C),
          out_valid, in_busy, 8'h20, '0);
    @(negedge clk); in_valid = '0;
    @(posedge clk); @(negedge clk);
    check("R3 clear", out_valid == '0, out_valid, in_busy, '0, '0);

    // R2 R4: every source to every port alone
    for (int s = 0; s < P; s++) begin
      for (int d = 0; d < P; d++) begin
        logic [P-1:0]    v  = '0;
        logic [P*LG-1:0] ds = '0;
        logic [P*DW-1:0] dt = '0;
        step_rand();
        v[s] = 1'b1;
        ds[s*LG +: LG] = LG'(d);
        dt[s*DW +: DW] = lfsr[DW-1:0];
        run_vec(v, ds, dt, "R2 R4 single");
      end
    end

    // R5 R6 R8: every pair of sources, every pair of tags
    for (int a = 0; a < P; a++) begin
      for (int b = a + 1; b < P; b++) begin
        for (int da = 0; da < P; da++) begin
          for (int db = 0; db < P; db++) begin
            logic [P-1:0]    v  = '0;
            logic [P*LG-1:0] ds = '0;
            logic [P*DW-1:0] dt = '0;
            v[a] = 1'b1; v[b] = 1'b1;
            ds[a*LG +: LG] = LG'(da); ds[b*LG +: LG] = LG'(db);
            dt[a*DW +: DW] = DW'(8'h10 + a); dt[b*DW +: DW] = DW'(8'h80 + b);
            run_vec(v, ds, dt, "R5 R6 R8 pair");
          end
        end
      end
    end

    // R9: cyclic shifts, fully routable
    for (int c = 0; c < P; c++) begin
      logic [P*LG-1:0] ds = '0;
      logic [P*DW-1:0] dt = '0;
      for (int i = 0; i < P; i++) begin
        ds[i*LG +: LG] = LG'((i + c) % P);
        dt[i*DW +: DW] = DW'(i * 17 + c);
      end
      run_vec('1, ds, dt, "R9 shift");
    end

    // R7 R8 R5: random masks, invalid inputs carry garbage
    for (int n = 0; n < 1500; n++) begin
      logic [P-1:0]    v;
      logic [P*LG-1:0] ds;
      logic [P*DW-1:0] dt;
      step_rand(); v = lfsr[P-1:0];
      for (int i = 0; i < P; i++) begin
        step_rand(); ds[i*LG +: LG] = lfsr[LG-1:0];
        step_rand(); dt[i*DW +: DW] = lfsr[DW-1:0];
      end
      run_vec(v, ds, dt, "R7 R8 random");
    end

    // R7: no valid inputs at all, busy must stay clear
    run_vec('0, '1, '1, "R7 idle");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule